// File: doc/BRIEF.md
# Battery Pack Protection State Controller

This block decides whether the series MOSFET pair of a battery pack conducts or disconnects. It does no analog work. Comparators outside it supply digital flags: overcharge, overdischarge, overcurrent, charger present, load present, and pack terminal at high impedance. It also takes a pack-enable input. Every input first passes through a multi-flop synchronizer. Each fault flag then has to stay high for a programmable run of consecutive clocks before it counts as a fault, so a glitch cannot open the pack.

Once a fault is latched, the pack stays disconnected until that fault's own recovery condition appears:
- an overdischarge clears when a charger is seen;
- an overcharge clears when a load is seen;
- an overcurrent clears when the terminal reads as high impedance.

Any fault can also be cleared by hand. Dropping the enable puts the block into power-down, and the following rising edge of enable returns it to conduction.

The gate is driven by two control channels that are computed independently. The pair can conduct only when both channels are high. The block also drives:
- a cell-bypass enable, which is high while an overcharge is latched;
- a MOSFET-bypass enable, which is high while an overcurrent is latched;
- a power-down indication;
- a sticky "full" flag.

Top module: `pack_guard_ctrl`

## Requirements
- R1: While reset is active, and after reset while enable stays low, the outputs are {gate_a, gate_b, cell_byp, fet_byp, pwrdn, full} = 000010.
- R2: When enable goes low, the block enters power-down within three clocks and shows 000010. Both gates stay off whatever the fault and recovery inputs do while enable is low.
- R3: A rising edge on the synchronized enable takes the block from power-down to conduction (110000 if no flag is set). Dropping enable and raising it again therefore clears any latched fault.
- R4: A fault flag latches only after it has been high for HOLD_CYC consecutive synchronized clocks. A pulse one clock shorter leaves the outputs unchanged.
- R5: If several qualified fault flags are present while the block conducts, it latches overcurrent first, then overdischarge, then overcharge.
- R6: A latched overdischarge turns both gates off and clears automatically when the charger flag is high, with no enable edge needed.
- R7: A latched overcharge turns both gates off and clears automatically when the load flag is high.
- R8: A latched overcurrent turns both gates off and clears automatically when the terminal high-impedance flag is high.
- R9: cell_byp is high exactly while an overcharge fault is latched.
- R10: fet_byp is high exactly while an overcurrent fault is latched. Dropping enable clears it together with the fault.
- R11: full rises on the clock that latches an overcharge. It stays high through load recovery and later faults, and clears only when enable goes low.
- R12: gate_a and gate_b are produced by separate decision logic, and both are high only in conduction.
- R13: A recovery flag that does not belong to the latched fault has no effect. For example, a charger or high impedance does not clear an overcharge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Pack enable; low means detached or floating |
| ovc_i | input | 1 | Overcharge comparator flag |
| ovd_i | input | 1 | Overdischarge comparator flag |
| ocur_i | input | 1 | Overcurrent comparator flag |
| chg_i | input | 1 | Charger-present flag |
| load_i | input | 1 | Load-present flag |
| hiz_i | input | 1 | Pack terminal reads high impedance |
| gate_a_o | output | 1 | Gate control, channel A |
| gate_b_o | output | 1 | Gate control, channel B |
| cell_byp_o | output | 1 | Cell-bypass enable |
| fet_byp_o | output | 1 | MOSFET-bypass enable |
| pwrdn_o | output | 1 | Power-down indication |
| full_o | output | 1 | Overcharge-reached status |

## Verification
Every output is a direct decode of the state register, or of channel B's latch bits. A wrong state therefore reaches the ports on the clock after it is entered, and the bench compares all six outputs as one vector at each check.

A fault latched against the priority order shows the wrong bypass output. A fault leaving on a foreign recovery flag shows the gates turning on too early. A corrupted full register shows up after load recovery, where the expected vector is 110001.

Any divergence between the two gate channels breaks the gate_a equals gate_b pattern at once.

// File: rtl/pack_guard_pkg.sv
package pack_guard_pkg;

   // Fault flag positions inside the qualified fault vector
   localparam int unsigned FLT_NUM  = 3;
   localparam int unsigned FLT_OCUR = 0;
   localparam int unsigned FLT_OVD  = 1;
   localparam int unsigned FLT_OVC  = 2;

   // Positions inside the synchronized input bundle
   localparam int unsigned IN_CHG   = 3;
   localparam int unsigned IN_LOAD  = 4;
   localparam int unsigned IN_HIZ   = 5;
   localparam int unsigned IN_EN    = 6;
   localparam int unsigned IN_NUM   = 7;

   typedef enum logic [2:0] {
      ST_PWRDN     = 3'd0,
      ST_CONDUCT   = 3'd1,
      ST_HOLD_OCUR = 3'd2,
      ST_HOLD_OVD  = 3'd3,
      ST_HOLD_OVC  = 3'd4
   } pg_state_e;

endpackage

// File: rtl/pg_sync_bank.sv
module pg_sync_bank #(
   parameter int unsigned WIDTH  = 7,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("pg_sync_bank: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("pg_sync_bank: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] pipe_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q[0] <= '0;
      else        pipe_q[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe_q[s] <= '0;
         else        pipe_q[s] <= pipe_q[s-1];
      end
   end

   assign q_o = pipe_q[LAST];

endmodule

// File: rtl/pg_persist_filter.sv
module pg_persist_filter #(
   parameter int unsigned HOLD = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flag_i,
   output logic qual_o
);

   if (HOLD < 1) begin : g_bad_hold
      $error("pg_persist_filter: HOLD must be at least 1");
   end

   if (HOLD == 1) begin : g_pass
      // A single clock of persistence needs no counter
      assign qual_o = flag_i;
   end else begin : g_count
      localparam int unsigned CW = $clog2(HOLD + 1);
      localparam logic [CW-1:0] LIM = CW'(HOLD);

      logic [CW-1:0] run_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             run_q <= '0;
         else if (!flag_i)       run_q <= '0;
         else if (run_q != LIM)  run_q <= run_q + 1'b1;
      end

      assign qual_o = (run_q == LIM);

      AST_QUAL_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
         qual_o |-> $past(flag_i)); // R4
      AST_GLITCH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
         !flag_i |=> !qual_o); // R4
   end

endmodule

// File: rtl/pg_state_core.sv
module pg_state_core
   import pack_guard_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_s_i,
   input  logic               en_rise_i,
   input  logic [FLT_NUM-1:0] qual_i,
   input  logic               chg_s_i,
   input  logic               load_s_i,
   input  logic               hiz_s_i,
   output logic               gate_a_o,
   output logic               cell_byp_o,
   output logic               fet_byp_o,
   output logic               pwrdn_o,
   output logic               full_o
);

   pg_state_e st_q, st_nxt;
   logic      full_q;
   logic      enter_ovc;

   always_comb begin
      st_nxt = st_q;
      case (st_q)
         ST_PWRDN:     if (en_rise_i) st_nxt = ST_CONDUCT;
         ST_CONDUCT: begin
            if      (qual_i[FLT_OCUR]) st_nxt = ST_HOLD_OCUR;
            else if (qual_i[FLT_OVD])  st_nxt = ST_HOLD_OVD;
            else if (qual_i[FLT_OVC])  st_nxt = ST_HOLD_OVC;
         end
         ST_HOLD_OCUR: if (hiz_s_i)  st_nxt = ST_CONDUCT;
         ST_HOLD_OVD:  if (chg_s_i)  st_nxt = ST_CONDUCT;
         ST_HOLD_OVC:  if (load_s_i) st_nxt = ST_CONDUCT;
         default:      st_nxt = ST_PWRDN;
      endcase
      if (!en_s_i) st_nxt = ST_PWRDN;
   end

   assign enter_ovc = (st_q == ST_CONDUCT) && (st_nxt == ST_HOLD_OVC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_PWRDN;
         full_q <= 1'b0;
      end else begin
         st_q <= st_nxt;
         if (!en_s_i)        full_q <= 1'b0;
         else if (enter_ovc) full_q <= 1'b1;
      end
   end

   assign gate_a_o   = (st_q == ST_CONDUCT);
   assign cell_byp_o = (st_q == ST_HOLD_OVC);
   assign fet_byp_o  = (st_q == ST_HOLD_OCUR);
   assign pwrdn_o    = (st_q == ST_PWRDN);
   assign full_o     = full_q;

   AST_DOWN_ON_EN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !en_s_i |=> (st_q == ST_PWRDN)); // R2
   AST_WAKE_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_PWRDN && !en_rise_i) |=> (st_q == ST_PWRDN)); // R3
   AST_OCUR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_CONDUCT && en_s_i && qual_i[FLT_OCUR]) |=> (st_q == ST_HOLD_OCUR)); // R5
   AST_OVD_WAITS_CHG: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HOLD_OVD && en_s_i && !chg_s_i) |=> (st_q == ST_HOLD_OVD)); // R6
   AST_OVC_WAITS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HOLD_OVC && en_s_i && !load_s_i) |=> (st_q == ST_HOLD_OVC)); // R7
   AST_OCUR_WAITS_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HOLD_OCUR && en_s_i && !hiz_s_i) |=> (st_q == ST_HOLD_OCUR)); // R8
   AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && en_s_i) |=> full_q); // R11

endmodule

// File: rtl/pg_interlock.sv
module pg_interlock
   import pack_guard_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_s_i,
   input  logic               en_rise_i,
   input  logic [FLT_NUM-1:0] qual_i,
   input  logic               chg_s_i,
   input  logic               load_s_i,
   input  logic               hiz_s_i,
   output logic               gate_b_o
);

   // Channel B keeps one latch bit per fault instead of an encoded state
   logic               armed_q;
   logic [FLT_NUM-1:0] lat_q, lat_set, lat_clr;
   logic [FLT_NUM-1:0] recov;
   logic               open_now;

   assign open_now = armed_q && (lat_q == '0);

   assign recov[FLT_OCUR] = hiz_s_i;
   assign recov[FLT_OVD]  = chg_s_i;
   assign recov[FLT_OVC]  = load_s_i;

   always_comb begin
      lat_set = '0;
      if (open_now) begin
         if      (qual_i[FLT_OCUR]) lat_set[FLT_OCUR] = 1'b1;
         else if (qual_i[FLT_OVD])  lat_set[FLT_OVD]  = 1'b1;
         else if (qual_i[FLT_OVC])  lat_set[FLT_OVC]  = 1'b1;
      end
   end

   for (genvar f = 0; f < FLT_NUM; f++) begin : g_lat
      assign lat_clr[f] = lat_q[f] && recov[f];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          lat_q[f] <= 1'b0;
         else if (!en_s_i)    lat_q[f] <= 1'b0;
         else if (lat_set[f]) lat_q[f] <= 1'b1;
         else if (lat_clr[f]) lat_q[f] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         armed_q <= 1'b0;
      else if (!en_s_i)   armed_q <= 1'b0;
      else if (en_rise_i) armed_q <= 1'b1;
   end

   assign gate_b_o = open_now;

   AST_ONE_FAULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lat_q)); // R5
   AST_CHAN_B_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      !en_s_i |=> !gate_b_o); // R2

endmodule

// File: rtl/pack_guard_ctrl.sv
module pack_guard_ctrl
   import pack_guard_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HOLD_CYC    = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic ovc_i,
   input  logic ovd_i,
   input  logic ocur_i,
   input  logic chg_i,
   input  logic load_i,
   input  logic hiz_i,
   output logic gate_a_o,
   output logic gate_b_o,
   output logic cell_byp_o,
   output logic fet_byp_o,
   output logic pwrdn_o,
   output logic full_o
);

   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("pack_guard_ctrl: HOLD_CYC must be at least 1");
   end

   logic [IN_NUM-1:0]  raw_in, syn_in;
   logic [FLT_NUM-1:0] qual;
   logic               en_d_q, en_rise;

   always_comb begin
      raw_in           = '0;
      raw_in[FLT_OCUR] = ocur_i;
      raw_in[FLT_OVD]  = ovd_i;
      raw_in[FLT_OVC]  = ovc_i;
      raw_in[IN_CHG]   = chg_i;
      raw_in[IN_LOAD]  = load_i;
      raw_in[IN_HIZ]   = hiz_i;
      raw_in[IN_EN]    = en_i;
   end

   pg_sync_bank #(.WIDTH(IN_NUM), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_in),
      .q_o   (syn_in)
   );

   for (genvar f = 0; f < FLT_NUM; f++) begin : g_filt
      pg_persist_filter #(.HOLD(HOLD_CYC)) u_filt (
         .clk    (clk),
         .rst_n  (rst_n),
         .flag_i (syn_in[f]),
         .qual_o (qual[f])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_d_q <= 1'b0;
      else        en_d_q <= syn_in[IN_EN];
   end
   assign en_rise = syn_in[IN_EN] && !en_d_q;

   pg_state_core u_chan_a (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_s_i     (syn_in[IN_EN]),
      .en_rise_i  (en_rise),
      .qual_i     (qual),
      .chg_s_i    (syn_in[IN_CHG]),
      .load_s_i   (syn_in[IN_LOAD]),
      .hiz_s_i    (syn_in[IN_HIZ]),
      .gate_a_o   (gate_a_o),
      .cell_byp_o (cell_byp_o),
      .fet_byp_o  (fet_byp_o),
      .pwrdn_o    (pwrdn_o),
      .full_o     (full_o)
   );

   pg_interlock u_chan_b (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_s_i    (syn_in[IN_EN]),
      .en_rise_i (en_rise),
      .qual_i    (qual),
      .chg_s_i   (syn_in[IN_CHG]),
      .load_s_i  (syn_in[IN_LOAD]),
      .hiz_s_i   (syn_in[IN_HIZ]),
      .gate_b_o  (gate_b_o)
   );

   AST_GATE_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      gate_a_o == gate_b_o); // R12
   AST_OFF_WHEN_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      pwrdn_o |-> (!gate_a_o && !gate_b_o)); // R2
   AST_BYPASS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(cell_byp_o && fet_byp_o)); // R9
   AST_FULL_WITH_CELL: assert property (@(posedge clk) disable iff (!rst_n)
      cell_byp_o |-> full_o); // R11

endmodule

// File: tb/pack_guard_ctrl_tb.sv
module pack_guard_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int HOLD       = 4;

   logic clk = 1'b0;
   logic rst_n;
   logic en_i, ovc_i, ovd_i, ocur_i, chg_i, load_i, hiz_i;
   logic gate_a_o, gate_b_o, cell_byp_o, fet_byp_o, pwrdn_o, full_o;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pack_guard_ctrl #(.SYNC_STAGES(2), .HOLD_CYC(HOLD)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (en_i),
      .ovc_i      (ovc_i),
      .ovd_i      (ovd_i),
      .ocur_i     (ocur_i),
      .chg_i      (chg_i),
      .load_i     (load_i),
      .hiz_i      (hiz_i),
      .gate_a_o   (gate_a_o),
      .gate_b_o   (gate_b_o),
      .cell_byp_o (cell_byp_o),
      .fet_byp_o  (fet_byp_o),
      .pwrdn_o    (pwrdn_o),
      .full_o     (full_o)
   );

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Vector order: {gate_a, gate_b, cell_byp, fet_byp, pwrdn, full}
   task automatic expect_out(input string req, input logic [5:0] exp);
      logic [5:0] act;
      act = {gate_a_o, gate_b_o, cell_byp_o, fet_byp_o, pwrdn_o, full_o};
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: outputs %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      en_i = 0; ovc_i = 0; ovd_i = 0; ocur_i = 0; chg_i = 0; load_i = 0; hiz_i = 0;
      idle(3);
      expect_out("R1 in reset", 6'b000010);
      rst_n = 1'b1;
      idle(5);
      expect_out("R1 enable low after reset", 6'b000010);
   endtask

   task automatic t_enable_on;
      en_i = 1'b1;
      idle(5);
      expect_out("R3 R12 conduction after enable rise", 6'b110000);
   endtask

   task automatic t_filter_ovc;
      ovc_i = 1'b1; idle(HOLD - 1); ovc_i = 1'b0;
      idle(8);
      expect_out("R4 short overcharge pulse ignored", 6'b110000);
      ovc_i = 1'b1; idle(HOLD); ovc_i = 1'b0;
      idle(6);
      expect_out("R4 R9 R11 overcharge latched at exact run", 6'b001001);
   endtask

   task automatic t_ovc_recover;
      chg_i = 1'b1; hiz_i = 1'b1;
      idle(6);
      expect_out("R13 charger/hiz do not clear overcharge", 6'b001001);
      chg_i = 1'b0; hiz_i = 1'b0; load_i = 1'b1;
      idle(5);
      expect_out("R7 R11 load clears overcharge, full held", 6'b110001);
      load_i = 1'b0;
      idle(3);
   endtask

   task automatic t_ovd_recover;
      ovd_i = 1'b1;
      idle(HOLD + 5);
      expect_out("R6 overdischarge latched", 6'b000001);
      ovd_i = 1'b0; load_i = 1'b1; hiz_i = 1'b1;
      idle(6);
      expect_out("R13 load/hiz do not clear overdischarge", 6'b000001);
      load_i = 1'b0; hiz_i = 1'b0; chg_i = 1'b1;
      idle(5);
      expect_out("R6 charger clears overdischarge", 6'b110001);
      chg_i = 1'b0;
      idle(3);
   endtask

   task automatic t_power_down;
      ocur_i = 1'b1; ovc_i = 1'b1; chg_i = 1'b1; en_i = 1'b0;
      idle(HOLD + 6);
      expect_out("R2 R11 power-down with flags active", 6'b000010);
      ocur_i = 1'b0; ovc_i = 1'b0; chg_i = 1'b0;
      idle(4);
      expect_out("R2 power-down held", 6'b000010);
   endtask

   task automatic t_priority;
      en_i = 1'b1;
      idle(5);
      expect_out("R12 both channels on", 6'b110000);
      ocur_i = 1'b1; ovd_i = 1'b1; ovc_i = 1'b1;
      idle(HOLD + 5);
      expect_out("R5 R10 overcurrent wins", 6'b000100);
      ocur_i = 1'b0; ovd_i = 1'b0; ovc_i = 1'b0;
      idle(6);
      expect_out("R8 overcurrent held without hiz", 6'b000100);
      hiz_i = 1'b1;
      idle(5);
      expect_out("R8 hiz clears overcurrent", 6'b110000);
      hiz_i = 1'b0;
      idle(3);
   endtask

   task automatic t_bypass_cancel;
      ocur_i = 1'b1;
      idle(HOLD + 5);
      expect_out("R10 fet bypass on", 6'b000100);
      ocur_i = 1'b0; en_i = 1'b0;
      idle(5);
      expect_out("R10 fet bypass cancelled by enable low", 6'b000010);
      en_i = 1'b1;
      idle(5);
      expect_out("R3 manual recovery after overcurrent", 6'b110000);
   endtask

   task automatic t_manual_ovd;
      ovd_i = 1'b1;
      idle(HOLD + 5);
      expect_out("R3 overdischarge before manual recovery", 6'b000000);
      ovd_i = 1'b0; en_i = 1'b0;
      idle(5);
      en_i = 1'b1;
      idle(5);
      expect_out("R3 manual recovery after overdischarge", 6'b110000);
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      t_reset();
      t_enable_on();
      t_filter_ovc();
      t_ovc_recover();
      t_ovd_recover();
      t_power_down();
      t_priority();
      t_bypass_cancel();
      t_manual_ovd();
      summary();
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 50000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run still active, actual hung expected done");
      summary();
      $finish;
   end

endmodule